// File: doc/BRIEF.md
# Multiword DMA Request Handshake Controller

This block sits on the device side of an IDE-style storage link and runs the request/acknowledge handshake of a multiword DMA transfer. A command layer arms it with a transfer direction and a length in 16-bit words. Once armed, it raises a request toward the host whenever the internal buffer can take part: it needs a word ready to send in the to-host direction, or free room in the from-host direction. It then waits for the host's active-low acknowledge and counts one word on the trailing (rising) edge of each host strobe that matches the direction.

The request is held until the host acknowledges it. While the host acknowledges, the request is dropped if the buffer runs dry or fills up, and it comes back only after the acknowledge has been released and the buffer can move data again. The request is dropped for good once the last word has moved.

Outside an armed transfer, the acknowledge input is masked, so a floating or stuck-low acknowledge has no effect. During an acknowledged burst both chip selects must stay negated. A strobe that completes while either chip select is asserted is reported as a protocol error and is not counted. An abort input returns the block to idle.

Top module: `dma_req_handshake`

## Requirements
- R1: After reset, `dma_req`, `dma_active`, `dma_done`, `proto_err`, `buf_pop` and `buf_push` are all 0.
- R2: When `arm` is high for one cycle while idle, with a nonzero `xfer_len` and the buffer able to move data, `dma_active` is 1 after that edge and `dma_req` is 1 one edge later. The buffer can move data when `buf_has_word` is high for to-host transfers (`dir_to_host`=1), or when `buf_has_room` is high for from-host transfers (`dir_to_host`=0).
- R3: While `host_ack_n` is high, a raised `dma_req` stays high even if the buffer stops being able to move data.
- R4: While the host acknowledges (`host_ack_n`=0), `dma_req` falls one edge after the buffer stops being able to move data. It is raised again only when the acknowledge has been released and the buffer can move data.
- R5: During an acknowledged transfer, the rising edge of the matching strobe moves one word. `host_rd_n` is the strobe for to-host transfers and `host_wr_n` for from-host transfers. The block registers a one-cycle `buf_pop` (to-host) or `buf_push` (from-host) pulse. On a push, `buf_wdata` holds the `host_din` value that was present while `host_wr_n` was low.
- R6: When the word that brings the count to zero completes, `dma_active` and `dma_req` go to 0 and `dma_done` pulses for one cycle. No request follows.
- R7: While no transfer is armed, `host_ack_n` and both strobes have no effect: no pop, no push and no error.
- R8: A matching strobe that completes during an acknowledge while `sel0_n` or `sel1_n` is low produces a one-cycle `proto_err` pulse. It moves no word and does not decrement the count.
- R9: `abort` high at an edge returns the block to idle, with `dma_active` and `dma_req` at 0.
- R10: `arm` with `xfer_len`=0 is ignored. `arm` while a transfer is active is ignored and leaves the remaining count unchanged.
- R11: A strobe of the opposite direction during an acknowledged transfer moves no word.
- R12: `host_dout` carries `buf_rdata` only while a to-host transfer is acknowledged and `host_rd_n` is low. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a transfer (one-cycle pulse) |
| dir_to_host | input | 1 | Direction sampled at arm: 1 device to host, 0 host to device |
| xfer_len | input | LEN_W | Transfer length in words, sampled at arm |
| abort | input | 1 | Return to idle |
| buf_has_word | input | 1 | Buffer holds a word to send |
| buf_has_room | input | 1 | Buffer has room for a word |
| buf_rdata | input | WORD_W | Word at the buffer head |
| buf_pop | output | 1 | One word consumed by the host |
| buf_push | output | 1 | One word written by the host |
| buf_wdata | output | WORD_W | Word written by the host |
| host_ack_n | input | 1 | Host DMA acknowledge, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| sel0_n | input | 1 | Host chip select 0, active low |
| sel1_n | input | 1 | Host chip select 1, active low |
| host_din | input | WORD_W | Data from host |
| host_dout | output | WORD_W | Data to host |
| dma_req | output | 1 | DMA request to host |
| dma_active | output | 1 | Transfer armed and words remain |
| dma_done | output | 1 | One-cycle pulse after the last word |
| proto_err | output | 1 | One-cycle pulse on a chip-select violation |

## Verification
The bench goes after the request's hold-until-acknowledge rule. A design that drops the request as soon as the buffer empties, before the host acknowledges, would lose the handshake. It checks that the request is not raised again while the acknowledge is still held, since a careless design re-requests in the middle of a burst. It checks that the count stops at the last word, where an off-by-one would either cut the transfer short or issue an extra request.

The bench also drives acknowledge and strobes with nothing armed, strobes of the wrong direction, and strobes with a chip select asserted. A design without masking would move phantom words or corrupt the count in these cases. It checks that an arm with zero length, or an arm during a transfer, leaves the count untouched, which shows up in how many strobes it takes to finish.

// File: rtl/dmah_pkg.sv
package dmah_pkg;

  // Whether the buffer side can move one word in the armed direction.
  function automatic logic flow_ready(input logic to_host,
                                      input logic have_word,
                                      input logic have_room);
    return to_host ? have_word : have_room;
  endfunction

  // Trailing edge of an active-low strobe: low last cycle, high now.
  function automatic logic trail_edge(input logic now_n, input logic last_n);
    return now_n & ~last_n;
  endfunction

  typedef struct packed {
    logic word;
    logic err;
  } strobe_ev_t;

endpackage

// File: rtl/dmah_strobe_det.sv
module dmah_strobe_det
  import dmah_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              to_host,
  input  logic              host_ack_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              sel0_n,
  input  logic              sel1_n,
  input  logic [WORD_W-1:0] host_din,
  output logic              ack_i,
  output strobe_ev_t        ev,
  output logic [WORD_W-1:0] wdata_q
);

  logic rd_last_n, wr_last_n;
  logic rd_trail, wr_trail, dir_trail, sel_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_last_n <= 1'b1;
      wr_last_n <= 1'b1;
      wdata_q   <= '0;
    end else begin
      rd_last_n <= host_rd_n;
      wr_last_n <= host_wr_n;
      if (!host_wr_n) wdata_q <= host_din;
    end
  end

  // The acknowledge is masked whenever no transfer is armed.
  assign ack_i     = active & ~host_ack_n;
  assign rd_trail  = trail_edge(host_rd_n, rd_last_n);
  assign wr_trail  = trail_edge(host_wr_n, wr_last_n);
  assign dir_trail = to_host ? rd_trail : wr_trail;
  assign sel_hit   = ~sel0_n | ~sel1_n;

  assign ev.word = ack_i & dir_trail & ~sel_hit;
  assign ev.err  = ack_i & dir_trail & sel_hit;

endmodule

// File: rtl/dmah_word_ctr.sv
module dmah_word_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             dir_to_host,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             abort,
  input  logic             word_ev,
  output logic             active,
  output logic             to_host,
  output logic [LEN_W-1:0] words_left,
  output logic             finish,
  output logic             done_q
);

  function automatic logic [LEN_W-1:0] dec_one(input logic [LEN_W-1:0] v);
    return v - {{(LEN_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic is_last(input logic [LEN_W-1:0] v);
    return v == {{(LEN_W-1){1'b0}}, 1'b1};
  endfunction

  logic start;
  assign start  = ~active & arm & (xfer_len != '0);
  assign finish = active & word_ev & is_last(words_left);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      to_host    <= 1'b0;
      words_left <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= finish & ~abort;
      if (abort) begin
        active <= 1'b0;
      end else if (start) begin
        active     <= 1'b1;
        to_host    <= dir_to_host;
        words_left <= xfer_len;
      end else if (active && word_ev) begin
        words_left <= dec_one(words_left);
        if (finish) active <= 1'b0;
      end
    end
  end

  // R5: each counted word takes exactly one off the remaining count
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && word_ev && !abort) |=> (words_left == $past(words_left) - 1'b1));

endmodule

// File: rtl/dmah_req_ctl.sv
module dmah_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic abort,
  input  logic finish,
  input  logic ack_i,
  input  logic flow_ok,
  output logic req_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (abort || !active || finish) begin
      req_q <= 1'b0;
    end else if (req_q && ack_i && !flow_ok) begin
      req_q <= 1'b0;
    end else if (!req_q && !ack_i && flow_ok) begin
      req_q <= 1'b1;
    end
  end

  // R3: request is held until the host acknowledges
  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack_i && !abort) |=> req_q);

  // R4: no re-request while the acknowledge is still held
  a_r4_no_rise_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && ack_i) |=> !req_q);

endmodule

// File: rtl/dma_req_handshake.sv
module dma_req_handshake
  import dmah_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              dir_to_host,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              abort,
  input  logic              buf_has_word,
  input  logic              buf_has_room,
  input  logic [WORD_W-1:0] buf_rdata,
  output logic              buf_pop,
  output logic              buf_push,
  output logic [WORD_W-1:0] buf_wdata,
  input  logic              host_ack_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              sel0_n,
  input  logic              sel1_n,
  input  logic [WORD_W-1:0] host_din,
  output logic [WORD_W-1:0] host_dout,
  output logic              dma_req,
  output logic              dma_active,
  output logic              dma_done,
  output logic              proto_err
);

  logic              ack_i, to_host, finish, flow_ok;
  logic [LEN_W-1:0]  words_left;
  logic [WORD_W-1:0] wdata_q;
  strobe_ev_t        ev;

  dmah_strobe_det #(.WORD_W(WORD_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .active(dma_active), .to_host(to_host),
    .host_ack_n(host_ack_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .sel0_n(sel0_n), .sel1_n(sel1_n), .host_din(host_din),
    .ack_i(ack_i), .ev(ev), .wdata_q(wdata_q)
  );

  dmah_word_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .arm(arm), .dir_to_host(dir_to_host),
    .xfer_len(xfer_len), .abort(abort), .word_ev(ev.word),
    .active(dma_active), .to_host(to_host), .words_left(words_left),
    .finish(finish), .done_q(dma_done)
  );

  assign flow_ok = flow_ready(to_host, buf_has_word, buf_has_room);

  dmah_req_ctl u_req (
    .clk(clk), .rst_n(rst_n), .active(dma_active), .abort(abort),
    .finish(finish), .ack_i(ack_i), .flow_ok(flow_ok), .req_q(dma_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_pop   <= 1'b0;
      buf_push  <= 1'b0;
      buf_wdata <= '0;
      proto_err <= 1'b0;
    end else begin
      buf_pop   <= ev.word & to_host & ~abort;
      buf_push  <= ev.word & ~to_host & ~abort;
      proto_err <= ev.err;
      if (ev.word && !to_host) buf_wdata <= wdata_q;
    end
  end

  assign host_dout = (ack_i && to_host && !host_rd_n) ? buf_rdata : '0;

  // R1: no request without an armed transfer
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_active |-> !dma_req);

  // R6: an active transfer always has words left
  a_r6_words_left: assert property (@(posedge clk) disable iff (!rst_n)
    dma_active |-> (words_left != '0));

  // R7: nothing moves on the cycle after an idle cycle
  a_r7_idle_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_active |=> (!buf_pop && !buf_push && !proto_err));

  // R8: a flagged strobe never moves a word
  a_r8_err_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (!buf_pop && !buf_push));

  // R5: at most one buffer action per cycle
  a_r5_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_pop, buf_push}));

endmodule

// File: tb/tb_dma_req_handshake.sv
module tb_dma_req_handshake;

  localparam int W = 16;
  localparam int L = 16;

  logic clk = 1'b0;
  logic rst_n, arm, dir_to_host, abort, buf_has_word, buf_has_room;
  logic [L-1:0] xfer_len;
  logic [W-1:0] buf_rdata, host_din, host_dout, buf_wdata;
  logic buf_pop, buf_push, host_ack_n, host_rd_n, host_wr_n, sel0_n, sel1_n;
  logic dma_req, dma_active, dma_done, proto_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dma_req_handshake #(.WORD_W(W), .LEN_W(L)) dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .dir_to_host(dir_to_host),
    .xfer_len(xfer_len), .abort(abort), .buf_has_word(buf_has_word),
    .buf_has_room(buf_has_room), .buf_rdata(buf_rdata), .buf_pop(buf_pop),
    .buf_push(buf_push), .buf_wdata(buf_wdata), .host_ack_n(host_ack_n),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .sel0_n(sel0_n),
    .sel1_n(sel1_n), .host_din(host_din), .host_dout(host_dout),
    .dma_req(dma_req), .dma_active(dma_active), .dma_done(dma_done),
    .proto_err(proto_err)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Arm, then wait two edges so the request can appear.
  task automatic do_arm(input logic to_host, input logic [L-1:0] len);
    @(negedge clk);
    arm = 1'b1; dir_to_host = to_host; xfer_len = len;
    @(negedge clk);
    arm = 1'b0;
    @(negedge clk);
  endtask

  // One strobe: low for one cycle, then high; sample after the rise edge.
  task automatic strobe(input logic use_rd, input logic [W-1:0] d,
                        output logic [W-1:0] dout_seen,
                        output logic [3:0] evs);
    if (use_rd) host_rd_n = 1'b0; else host_wr_n = 1'b0;
    host_din = d;
    @(negedge clk);
    dout_seen = host_dout;
    host_rd_n = 1'b1; host_wr_n = 1'b1;
    @(negedge clk);
    evs = {buf_pop, buf_push, proto_err, dma_done};
  endtask

  task automatic t_reset;
    chk("R1 req after reset", dma_req, 0);
    chk("R1 active after reset", dma_active, 0);
    chk("R1 pop/push/err/done after reset", {buf_pop, buf_push, proto_err, dma_done}, 0);
  endtask

  task automatic t_read_burst;
    logic [W-1:0] d; logic [3:0] e;
    buf_has_word = 1'b1;
    do_arm(1'b1, 16'd3);
    chk("R2 active after arm", dma_active, 1);
    chk("R2 req raised", dma_req, 1);
    host_ack_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      buf_rdata = 16'hA000 + 16'(k);
      strobe(1'b1, 16'h0, d, e);
      chk("R12 read data out", d, 16'hA000 + k);
      chk("R5 pop per read word", e[3:2], 2'b10);
      chk("R6 done only on last", e[0], (k == 2) ? 1 : 0);
    end
    chk("R6 inactive after last", dma_active, 0);
    chk("R6 req low after last", dma_req, 0);
    host_ack_n = 1'b1;
    step(3);
    chk("R6 no request after finish", dma_req, 0);
    chk("R12 dout idle zero", host_dout, 0);
  endtask

  task automatic t_hold;
    buf_has_word = 1'b1;
    do_arm(1'b1, 16'd4);
    chk("R2 req raised (hold test)", dma_req, 1);
    buf_has_word = 1'b0;
    step(3);
    chk("R3 req held without ack", dma_req, 1);
    host_ack_n = 1'b0;
    step(1);
    chk("R4 req drops in ack when empty", dma_req, 0);
    buf_has_word = 1'b1;
    step(2);
    chk("R4 no re-request while ack held", dma_req, 0);
    host_ack_n = 1'b1;
    step(1);
    chk("R4 re-request after ack released", dma_req, 1);
    abort = 1'b1;
    step(1);
    abort = 1'b0;
    chk("R9 abort clears active", dma_active, 0);
    chk("R9 abort clears req", dma_req, 0);
  endtask

  task automatic t_write_burst;
    logic [W-1:0] d; logic [3:0] e;
    buf_has_room = 1'b1;
    do_arm(1'b0, 16'd2);
    chk("R2 req raised (write)", dma_req, 1);
    host_ack_n = 1'b0;
    strobe(1'b0, 16'h1234, d, e);
    chk("R5 push on write", e[3:2], 2'b01);
    chk("R5 write data", buf_wdata, 16'h1234);
    chk("R12 dout zero in write", d, 0);
    strobe(1'b1, 16'h0, d, e);
    chk("R11 opposite strobe ignored", e[3:2], 2'b00);
    strobe(1'b0, 16'hBEEF, d, e);
    chk("R5 second write data", buf_wdata, 16'hBEEF);
    chk("R6 done after two words", e[0], 1);
    host_ack_n = 1'b1;
    step(1);
  endtask

  task automatic t_idle_ack;
    logic [W-1:0] d; logic [3:0] e;
    host_ack_n = 1'b0;
    buf_rdata = 16'h5555;
    strobe(1'b1, 16'h0, d, e);
    chk("R7 idle read ignored", e, 0);
    chk("R12 idle dout zero", d, 0);
    strobe(1'b0, 16'h7777, d, e);
    chk("R7 idle write ignored", e, 0);
    host_ack_n = 1'b1;
    chk("R7 still idle", dma_active, 0);
  endtask

  task automatic t_sel_err_and_arm_rules;
    logic [W-1:0] d; logic [3:0] e;
    do_arm(1'b1, 16'd0);
    chk("R10 zero length ignored", dma_active, 0);
    buf_has_word = 1'b1;
    do_arm(1'b1, 16'd2);
    do_arm(1'b1, 16'd9);
    chk("R10 re-arm keeps active", dma_active, 1);
    host_ack_n = 1'b0;
    sel0_n = 1'b0;
    strobe(1'b1, 16'h0, d, e);
    sel0_n = 1'b1;
    chk("R8 err flagged, no pop", e[3:1], 3'b001);
    strobe(1'b1, 16'h0, d, e);
    chk("R8 count untouched by error", {e[3], e[0], dma_active}, 3'b101);
    strobe(1'b1, 16'h0, d, e);
    chk("R10 finish at original length", {e[0], dma_active}, 2'b10);
    host_ack_n = 1'b1;
    step(1);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; arm = 1'b0; dir_to_host = 1'b0; xfer_len = '0; abort = 1'b0;
    buf_has_word = 1'b0; buf_has_room = 1'b0; buf_rdata = '0; host_din = '0;
    host_ack_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
    sel0_n = 1'b1; sel1_n = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_read_burst();
    t_hold();
    t_write_burst();
    t_idle_ack();
    t_sel_err_and_arm_rules();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule